// File: doc/BRIEF.md
# SPI Status Flags and Register Control with Debug-Break Protection

This block is the processor-facing half of an 8-bit full-duplex SPI peripheral. It holds the control bits, the transmit and receive data registers and three status flags: transmit-empty, receive-full and overflow. The serial shift engine is outside the block. The engine returns a `done` strobe with each received byte and a `loaded` strobe each time it takes the pending transmit byte. The block raises a one-cycle start pulse when software hands it a new byte.

Receive-full and overflow clear in two steps. First, a status read that sees the flag set arms a per-flag latch. Then a read of the data register clears every armed flag. A debug-break input freezes this machinery unless the break-clear-enable bit is set. While it is frozen, processor accesses during break neither arm nor clear any flag, and a data write is thrown away. A first step made before the break survives it, so the second step made after the break still completes the clear.

The block also drives registered pin controls. It enables the MISO driver only as a selected slave, enables the MOSI driver only as master, and overrides the port's direction register while the SPI is enabled.

Top module: `spi_flag_ctl`

## Requirements
- R1: Register map: address 0 is control (bit0 enable, bit1 master, bit2 break-clear-enable), address 1 is status (bit0 transmit-empty, bit1 receive-full, bit2 overflow), address 2 is data. Read data appears on `cpu_rdata_o` one cycle after the access. After reset, control reads 0, status reads 0x01 and all pin controls are 0.
- R2: While `brk_i` is 1 and break-clear-enable is 0, processor reads and writes leave all three flags unchanged, and a status read in that state does not arm a clear.
- R3: While break-clear-enable is 1, a two-step clear done entirely during break clears the flag, and the flag stays clear after `brk_i` falls. A data write during break is then accepted.
- R4: If a status read armed a flag before break, a data read during break with break-clear-enable 0 does not clear it, and a data read after break ends does clear it.
- R5: A data-register write during break with break-clear-enable 0 is discarded: transmit-empty stays 1, `tx_start_o` stays 0 and `tx_byte_o` keeps its previous value.
- R6: A data write outside break clears transmit-empty and, one cycle later, pulses `tx_start_o` for one cycle with `tx_byte_o` equal to the written byte. `eng_loaded_i` sets transmit-empty again. If the write and the strobe fall in the same cycle, the write wins.
- R7: One cycle after the inputs settle, `miso_oe_o` = enable AND NOT master AND NOT `ss_n_i`, `mosi_oe_o` = enable AND master, and `dir_ovr_o` = enable.
- R8: `eng_done_i` sets receive-full and captures `eng_rx_i` into the receive register. A status read that sees receive-full, followed by a data read, clears it.
- R9: A byte completing while receive-full stays set sets overflow and is dropped, so the receive register keeps the older byte. Overflow clears by the same two-step sequence.
- R10: A set event cancels any armed clear of that flag, so a data read after a new set and with no fresh status read leaves the flag set. A `done` in the same cycle as the clearing data read leaves receive-full set, sets no overflow and captures the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_i | input | 1 | Debug-break state |
| cpu_sel_i | input | 1 | Register access strobe |
| cpu_wr_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | 2 | Register address |
| cpu_wdata_i | input | DATA_W | Write data |
| cpu_rdata_o | output | DATA_W | Registered read data |
| eng_done_i | input | 1 | Shift engine finished a byte |
| eng_rx_i | input | DATA_W | Byte received by the engine |
| eng_loaded_i | input | 1 | Engine took the transmit byte |
| tx_start_o | output | 1 | One-cycle pulse: new transmit byte ready |
| tx_byte_o | output | DATA_W | Transmit byte for the engine |
| ss_n_i | input | 1 | Slave select, active low |
| miso_oe_o | output | 1 | MISO driver enable |
| mosi_oe_o | output | 1 | MOSI driver enable |
| dir_ovr_o | output | 1 | Pin direction override |

## Verification
The critical collision is a shift-engine `done` landing in the same cycle as the data read that completes a receive-full clear. In that cycle the set path and the clear path both act on the same flag and on the overflow decision. The bench arms the flag with a status read, then holds `eng_done_i` high during the clearing data read. It expects receive-full still set, overflow still clear, and the new byte returned by the next data read. A second collision pairs a data write with `eng_loaded_i` in one cycle and expects transmit-empty to read 0.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL = 2'd0,
    A_STAT = 2'd1,
    A_DATA = 2'd2
  } reg_addr_e;

  localparam int CTL_EN   = 0;
  localparam int CTL_MSTR = 1;
  localparam int CTL_BCE  = 2;
  localparam int CTL_W    = 3;

  localparam int ST_TXE = 0;
  localparam int ST_RXF = 1;
  localparam int ST_OVF = 2;

  localparam int NFLAG = 2;  // two-step flags: index 0 receive-full, 1 overflow

  typedef struct packed {
    logic bce;
    logic mstr;
    logic en;
  } ctl_t;
endpackage

// File: rtl/spi_flag_cell.sv
module spi_flag_cell (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic look_i,
  input  logic allow_i,
  input  logic clr_i,
  output logic flag_o,
  output logic arm_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o <= 1'b0;
      arm_o  <= 1'b0;
    end else if (set_i) begin
      flag_o <= 1'b1;
      arm_o  <= 1'b0;
    end else if (clr_i) begin
      flag_o <= 1'b0;
      arm_o  <= 1'b0;
    end else if (allow_i && look_i && flag_o) begin
      arm_o <= 1'b1;
    end
  end
endmodule

// File: rtl/spi_pin_ctl.sv
module spi_pin_ctl (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic mstr_i,
  input  logic ss_n_i,
  output logic miso_oe_o,
  output logic mosi_oe_o,
  output logic dir_ovr_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      miso_oe_o <= 1'b0;
      mosi_oe_o <= 1'b0;
      dir_ovr_o <= 1'b0;
    end else begin
      miso_oe_o <= en_i && !mstr_i && !ss_n_i;
      mosi_oe_o <= en_i && mstr_i;
      dir_ovr_o <= en_i;
    end
  end
endmodule

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              brk_i,
  input  logic              cpu_sel_i,
  input  logic              cpu_wr_i,
  input  logic [1:0]        cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              eng_done_i,
  input  logic [DATA_W-1:0] eng_rx_i,
  input  logic              eng_loaded_i,
  output logic              tx_start_o,
  output logic [DATA_W-1:0] tx_byte_o,
  input  logic              ss_n_i,
  output logic              miso_oe_o,
  output logic              mosi_oe_o,
  output logic              dir_ovr_o
);
  ctl_t              ctl_q;
  logic              txe_q;
  logic [DATA_W-1:0] rx_q;
  logic [NFLAG-1:0]  flag_w, arm_w, set_w, clr_w;
  logic              allow, acc_rd, acc_wr, look, step2, wr_ok, rx_busy;
  logic [DATA_W-1:0] ctl_word, st_word;

  assign allow   = !brk_i || ctl_q.bce;
  assign acc_rd  = cpu_sel_i && !cpu_wr_i;
  assign acc_wr  = cpu_sel_i && cpu_wr_i;
  assign look    = acc_rd && (cpu_addr_i == A_STAT);
  assign step2   = acc_rd && (cpu_addr_i == A_DATA);
  assign wr_ok   = acc_wr && (cpu_addr_i == A_DATA) && allow;

  // receive-full stays set past this cycle
  assign rx_busy = flag_w[0] && !clr_w[0];
  assign set_w[0] = eng_done_i;
  assign set_w[1] = eng_done_i && rx_busy;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    assign clr_w[i] = allow && step2 && arm_w[i] && flag_w[i];
    spi_flag_cell u_cell (
      .clk    (clk),
      .rst    (rst),
      .set_i  (set_w[i]),
      .look_i (look),
      .allow_i(allow),
      .clr_i  (clr_w[i]),
      .flag_o (flag_w[i]),
      .arm_o  (arm_w[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (acc_wr && (cpu_addr_i == A_CTRL)) begin
      ctl_q <= ctl_t'(cpu_wdata_i[CTL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      txe_q      <= 1'b1;
      tx_start_o <= 1'b0;
      tx_byte_o  <= '0;
    end else begin
      tx_start_o <= wr_ok;
      if (wr_ok) begin
        txe_q     <= 1'b0;
        tx_byte_o <= cpu_wdata_i;
      end else if (eng_loaded_i) begin
        txe_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= '0;
    end else if (eng_done_i && !rx_busy) begin
      rx_q <= eng_rx_i;
    end
  end

  always_comb begin
    ctl_word           = '0;
    ctl_word[CTL_EN]   = ctl_q.en;
    ctl_word[CTL_MSTR] = ctl_q.mstr;
    ctl_word[CTL_BCE]  = ctl_q.bce;
    st_word            = '0;
    st_word[ST_TXE]    = txe_q;
    st_word[ST_RXF]    = flag_w[0];
    st_word[ST_OVF]    = flag_w[1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata_o <= '0;
    end else if (acc_rd) begin
      case (cpu_addr_i)
        A_CTRL:  cpu_rdata_o <= ctl_word;
        A_STAT:  cpu_rdata_o <= st_word;
        A_DATA:  cpu_rdata_o <= rx_q;
        default: cpu_rdata_o <= '0;
      endcase
    end
  end

  spi_pin_ctl u_pins (
    .clk      (clk),
    .rst      (rst),
    .en_i     (ctl_q.en),
    .mstr_i   (ctl_q.mstr),
    .ss_n_i   (ss_n_i),
    .miso_oe_o(miso_oe_o),
    .mosi_oe_o(mosi_oe_o),
    .dir_ovr_o(dir_ovr_o)
  );
endmodule

// File: rtl/spi_flag_chk.sv
module spi_flag_chk (
  input logic       clk,
  input logic       rst,
  input logic       brk,
  input logic       bce,
  input logic       cpu_sel,
  input logic       cpu_wr,
  input logic [1:0] cpu_addr,
  input logic       eng_done,
  input logic       eng_loaded,
  input logic [1:0] flags,
  input logic       txe,
  input logic       tx_start,
  input logic       miso_oe,
  input logic       mosi_oe
);
  AST_BRK_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (brk && !bce && !eng_done && !eng_loaded) |=> $stable({flags, txe})); // R2
  AST_BRK_NO_START: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel && cpu_wr && cpu_addr == 2'd2 && brk && !bce) |=> !tx_start); // R5
  AST_TXE_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(txe) |-> $past(eng_loaded)); // R6
  AST_START_TXE: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !txe); // R6
  AST_PIN_EXCL: assert property (@(posedge clk) disable iff (rst)
    miso_oe |-> !mosi_oe); // R7
  AST_RXF_SRC: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(eng_done)); // R8
  AST_OVF_NEEDS_RXF: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[1]) |-> $past(flags[0])); // R9
endmodule

bind spi_flag_ctl spi_flag_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .brk       (brk_i),
  .bce       (ctl_q.bce),
  .cpu_sel   (cpu_sel_i),
  .cpu_wr    (cpu_wr_i),
  .cpu_addr  (cpu_addr_i),
  .eng_done  (eng_done_i),
  .eng_loaded(eng_loaded_i),
  .flags     (flag_w),
  .txe       (txe_q),
  .tx_start  (tx_start_o),
  .miso_oe   (miso_oe_o),
  .mosi_oe   (mosi_oe_o)
);

// File: tb/tb_spi_flag_ctl.sv
`timescale 1ns/1ps
module tb_spi_flag_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       brk_i = 1'b0, cpu_sel_i = 1'b0, cpu_wr_i = 1'b0;
  logic [1:0] cpu_addr_i = '0;
  logic [7:0] cpu_wdata_i = '0, eng_rx_i = '0;
  logic       eng_done_i = 1'b0, eng_loaded_i = 1'b0, ss_n_i = 1'b1;
  logic [7:0] cpu_rdata_o, tx_byte_o;
  logic       tx_start_o, miso_oe_o, mosi_oe_o, dir_ovr_o;

  int nchk = 0, nfail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_flag_ctl #(.DATA_W(8)) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, output logic st);
    cpu_sel_i = 1; cpu_wr_i = 1; cpu_addr_i = a; cpu_wdata_i = d;
    @(negedge clk);
    st = tx_start_o;
    cpu_sel_i = 0; cpu_wr_i = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cpu_sel_i = 1; cpu_wr_i = 0; cpu_addr_i = a;
    @(negedge clk);
    d = cpu_rdata_o;
    cpu_sel_i = 0;
  endtask

  task automatic done(input logic [7:0] b);
    eng_done_i = 1; eng_rx_i = b;
    @(negedge clk);
    eng_done_i = 0;
  endtask

  task automatic loaded();
    eng_loaded_i = 1;
    @(negedge clk);
    eng_loaded_i = 0;
  endtask

  initial begin
    logic [7:0] d;
    logic st;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // reset state
    rd(2'd1, d); chk("R1 status", d, 8'h01);
    rd(2'd0, d); chk("R1 control", d, 8'h00);
    chk("R1 pins", {miso_oe_o, mosi_oe_o, dir_ovr_o}, 0);

    // pin sweep over enable, master, slave select
    for (int k = 0; k < 8; k++) begin
      ss_n_i = k[2];
      wr(2'd0, {6'd0, k[1], k[0]}, st);
      @(negedge clk);
      chk("R7 miso_oe", miso_oe_o, int'(k[0] && !k[1] && !k[2]));
      chk("R7 mosi_oe", mosi_oe_o, int'(k[0] && k[1]));
      chk("R7 dir_ovr", dir_ovr_o, int'(k[0]));
    end

    wr(2'd0, 8'h01, st);
    // transmit path
    wr(2'd2, 8'hA5, st);
    chk("R6 start", st, 1); chk("R6 byte", tx_byte_o, 8'hA5);
    @(negedge clk); chk("R6 pulse one cycle", tx_start_o, 0);
    rd(2'd1, d); chk("R6 txe clear", d, 8'h00);
    loaded();
    rd(2'd1, d); chk("R6 txe set", d, 8'h01);
    // write and loaded strobe in the same cycle: write wins
    eng_loaded_i = 1; wr(2'd2, 8'h5A, st); eng_loaded_i = 0;
    rd(2'd1, d); chk("R6 write beats loaded", d, 8'h00);
    loaded();

    // receive and two-step clear
    done(8'h3C);
    rd(2'd1, d); chk("R8 rxf set", d, 8'h03);
    rd(2'd2, d); chk("R8 rx byte", d, 8'h3C);
    rd(2'd1, d); chk("R8 rxf cleared", d, 8'h01);

    // overflow
    done(8'h11); done(8'h22);
    rd(2'd1, d); chk("R9 ovf set", d, 8'h07);
    rd(2'd2, d); chk("R9 old byte kept", d, 8'h11);
    rd(2'd1, d); chk("R9 both cleared", d, 8'h01);

    // set cancels arm
    done(8'h33);
    rd(2'd1, d);
    done(8'h44);
    rd(2'd2, d); chk("R10 byte", d, 8'h33);
    rd(2'd1, d); chk("R10 arm cancelled", d, 8'h07);
    rd(2'd2, d);
    rd(2'd1, d); chk("R10 cleared after rearm", d, 8'h01);

    // done colliding with the clearing data read
    done(8'h55);
    rd(2'd1, d);
    eng_done_i = 1; eng_rx_i = 8'h66; rd(2'd2, d); eng_done_i = 0;
    chk("R10 collide read old", d, 8'h55);
    rd(2'd1, d); chk("R10 collide rxf set no ovf", d, 8'h03);
    rd(2'd2, d); chk("R10 collide new byte", d, 8'h66);
    rd(2'd1, d); chk("R10 collide cleared", d, 8'h01);

    // armed before break, break with clear disabled
    done(8'h77);
    rd(2'd1, d);
    brk_i = 1;
    rd(2'd2, d); chk("R4 data in break", d, 8'h77);
    rd(2'd1, d); chk("R2 rxf frozen", d, 8'h03);
    wr(2'd2, 8'h99, st);
    chk("R5 no start", st, 0); chk("R5 byte kept", tx_byte_o, 8'h5A);
    rd(2'd1, d); chk("R5 txe stays", d, 8'h03);
    brk_i = 0;
    rd(2'd2, d);
    rd(2'd1, d); chk("R4 cleared after break", d, 8'h01);

    // status read in break does not arm
    done(8'h88);
    brk_i = 1;
    rd(2'd1, d);
    brk_i = 0;
    rd(2'd2, d);
    rd(2'd1, d); chk("R2 no arm in break", d, 8'h03);
    rd(2'd2, d);
    rd(2'd1, d); chk("R2 clear after", d, 8'h01);

    // break with clear enabled
    wr(2'd0, 8'h05, st);
    rd(2'd0, d); chk("R1 control readback", d, 8'h05);
    done(8'hAB);
    brk_i = 1;
    rd(2'd1, d);
    rd(2'd2, d); chk("R3 byte", d, 8'hAB);
    rd(2'd1, d); chk("R3 cleared in break", d, 8'h01);
    wr(2'd2, 8'hC3, st); chk("R3 write accepted", st, 1);
    brk_i = 0;
    rd(2'd1, d); chk("R3 stays clear", d, 8'h00);
    loaded();

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog (R1..) act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule